// File: doc/BRIEF.md
# Six-Channel Programmable Interval Timer

This peripheral holds six independent timer channels behind a small 32-bit register bus with single-cycle read and write strobes. Each channel has a control word, a clock-select word, a read-only up-counter and a compare value. A channel counts qualified ticks. The ticks come from one of two tick-enable inputs, which stand in for a fast and a slow reference clock, optionally divided by two. When its count meets the compare value, the channel raises a pending flag. What happens next depends on the channel's mode: one-shot, repeat or free-running.

A shared enable register gates the six pending flags onto one registered level interrupt. A shared acknowledge register clears them: writing a one to a bit clears that bit. Software typically sets one channel in free-running mode as a monotonic time base and uses another channel in repeat or one-shot mode to generate timed events.

Top module: `gp_timer_bank`

## Requirements
- R1: Byte offsets are fixed. For channel n (1..6), the control word is at 0x10*n, the clock select at 0x10*n+0x04, the counter at 0x10*n+0x08 and the compare value at 0x10*n+0x0C. The interrupt enable is at 0x00 and the pending/acknowledge word is at 0x08. Channel n uses bit n-1 in both shared words. A read returns data on bus_rdata one clock after the read strobe. After reset every readable word is 0 and irq is 0.
- R2: In the control word, bit 0 enables the channel and bits [5:4] select the mode: 0 = one-shot, 1 = repeat, 3 = free-run. Bit 1 is a clear command. It zeroes the counter in the same write that may set the enable, and it always reads back as 0.
- R3: While a channel is enabled, each qualified tick adds one to its counter. Bus writes to the counter offset are ignored.
- R4: In the clock-select word, bit 4 picks the tick source (0 = tick_fast, 1 = tick_slow). Bit 0 picks divide-by-1 (0) or divide-by-2 (1). With divide-by-2, K source ticks after a clear give floor(K/2) counts.
- R5: In repeat mode, a qualified tick that finds the count equal to the compare value sets the pending bit and restarts the counter at 0. K ticks after a clear therefore leave K mod (C+1) in the counter.
- R6: In one-shot mode, a matching tick sets the pending bit, leaves the counter at the compare value, and clears the channel's enable bit.
- R7: In free-run mode (and for the unused mode value 2), the counter never sets a pending bit and wraps to 0 after its largest value.
- R8: A pending bit sets whether or not its enable bit is set. irq is high exactly when some channel is both pending and enabled.
- R9: Reading 0x08 returns the pending bits. Writing 0x08 clears each pending bit whose data bit is 1, so 0x3F clears all six at once.
- R10: When an acknowledge write and a new match hit the same channel in the same cycle, the pending bit remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_fast | input | 1 | Tick enable of the fast reference |
| tick_slow | input | 1 | Tick enable of the slow reference |
| irq | output | 1 | Combined level interrupt |

## Verification
On every cycle the assertions check the pending-flag rules: a match always leaves its flag set (including the collision with an acknowledge), an acknowledge without a match clears it, and a flag otherwise holds. They also check that irq tracks pending AND enable, that a one-shot match drops the enable, and that the clear bit reads as 0. The counter arithmetic can only be shown by the bench's scenarios. These cover the swept compare and tick counts in one-shot and repeat modes, free-run wrap, source selection, the divide-by-2 sequence and the ignored counter write. The bench uses an 8-bit counter so that a wrap is reachable.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  typedef enum logic [1:0] {
    MODE_ONCE   = 2'd0,
    MODE_REPEAT = 2'd1,
    MODE_SPARE  = 2'd2,
    MODE_FREE   = 2'd3
  } gpt_mode_e;

  // word select inside a 16-byte channel window (address bits [3:2])
  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_CKSEL = 2'd1;
  localparam logic [1:0] SEL_COUNT = 2'd2;
  localparam logic [1:0] SEL_CMP   = 2'd3;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_CLR_BIT = 1;
  localparam int CTRL_MODE_LO = 4;
  localparam int CK_DIV_BIT   = 0;
  localparam int CK_SRC_BIT   = 4;

  function automatic logic mode_raises(gpt_mode_e m);
    return (m == MODE_ONCE) || (m == MODE_REPEAT);
  endfunction

endpackage

// File: rtl/gpt_tick_sel.sv
module gpt_tick_sel (
  input  logic clk,
  input  logic rst,
  input  logic tick_fast,
  input  logic tick_slow,
  input  logic use_slow,
  input  logic div2,
  input  logic restart,
  output logic tick
);

  logic src_tick;
  logic phase_q;

  assign src_tick = use_slow ? tick_slow : tick_fast;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase_q <= 1'b0;
    end else if (src_tick && div2) begin
      phase_q <= ~phase_q;
    end
  end

  assign tick = src_tick && (!div2 || phase_q);

endmodule

// File: rtl/gpt_channel.sv
module gpt_channel
  import gpt_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_fast,
  input  logic             tick_slow,
  input  logic             wr_ctrl,
  input  logic             wr_cksel,
  input  logic             wr_cmp,
  input  logic [DW-1:0]    wdata,
  output logic             en_o,
  output gpt_mode_e        mode_o,
  output logic             use_slow_o,
  output logic             div2_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             match_o
);

  logic             en_q;
  gpt_mode_e        mode_q;
  logic             slow_q;
  logic             div2_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_q;
  logic             clr_cmd;
  logic             tick;
  logic             hit;

  assign clr_cmd = wr_ctrl && wdata[CTRL_CLR_BIT];

  gpt_tick_sel u_tick (
    .clk      (clk),
    .rst      (rst),
    .tick_fast(tick_fast),
    .tick_slow(tick_slow),
    .use_slow (slow_q),
    .div2     (div2_q),
    .restart  (clr_cmd),
    .tick     (tick)
  );

  assign hit     = tick && en_q && (cnt_q == cmp_q);
  assign match_o = hit && mode_raises(mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      slow_q <= 1'b0;
      div2_q <= 1'b0;
      cmp_q  <= '0;
    end else begin
      if (wr_cksel) begin
        slow_q <= wdata[CK_SRC_BIT];
        div2_q <= wdata[CK_DIV_BIT];
      end
      if (wr_cmp) begin
        cmp_q <= wdata[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clr_cmd) begin
      cnt_q <= '0;
    end else if (tick && en_q) begin
      unique case (mode_q)
        MODE_REPEAT: cnt_q <= hit ? '0 : cnt_q + 1'b1;
        MODE_ONCE:   if (!hit) cnt_q <= cnt_q + 1'b1;
        default:     cnt_q <= cnt_q + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      mode_q <= MODE_ONCE;
    end else if (wr_ctrl) begin
      en_q   <= wdata[CTRL_EN_BIT];
      mode_q <= gpt_mode_e'(wdata[CTRL_MODE_LO +: 2]);
    end else if (hit && (mode_q == MODE_ONCE)) begin
      en_q <= 1'b0;
    end
  end

  assign en_o       = en_q;
  assign mode_o     = mode_q;
  assign use_slow_o = slow_q;
  assign div2_o     = div2_q;
  assign count_o    = cnt_q;
  assign cmp_o      = cmp_q;

endmodule

// File: rtl/gpt_irq_ctrl.sv
module gpt_irq_ctrl #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_ie,
  input  logic           wr_ack,
  input  logic [NCH-1:0] wbits,
  input  logic [NCH-1:0] match,
  output logic [NCH-1:0] ie_o,
  output logic [NCH-1:0] pend_o,
  output logic           irq_o
);

  logic [NCH-1:0] ie_q, ie_n;
  logic [NCH-1:0] pend_q, pend_n;
  logic [NCH-1:0] ack_mask;
  logic           irq_q;

  assign ack_mask = wr_ack ? wbits : '0;
  assign pend_n   = (pend_q & ~ack_mask) | match;
  assign ie_n     = wr_ie ? wbits : ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      ie_q   <= ie_n;
      pend_q <= pend_n;
      irq_q  <= |(pend_n & ie_n);
    end
  end

  assign ie_o   = ie_q;
  assign pend_o = pend_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/gp_timer_bank.sv
module gp_timer_bank
  import gpt_pkg::*;
#(
  parameter int NCH   = 6,
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int CNT_W = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tick_fast,
  input  logic          tick_slow,
  output logic          irq
);

  localparam int IDX_W = AW - 4;

  logic [IDX_W-1:0] win;
  logic [1:0]       sel;
  logic             aligned;
  logic             wr_ie, wr_ack;

  logic [NCH-1:0]   match_v, en_v, once_v, wr_ctrl_v;
  logic [NCH-1:0]   ie_v, pend_v;
  logic [NCH-1:0][DW-1:0] chan_word;
  logic [DW-1:0]    rd_mux;
  logic [DW-1:0]    rdata_q;

  assign win     = bus_addr[AW-1:4];
  assign sel     = bus_addr[3:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_ie   = bus_wr && aligned && (win == '0) && (sel == 2'd0);
  assign wr_ack  = bus_wr && aligned && (win == '0) && (sel == 2'd2);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic             here;
    logic             slow_w, div2_w;
    gpt_mode_e        mode_w;
    logic [CNT_W-1:0] cnt_w, cmp_w;
    logic [DW-1:0]    word;

    assign here         = aligned && (win == IDX_W'(g + 1));
    assign wr_ctrl_v[g] = bus_wr && here && (sel == SEL_CTRL);
    assign once_v[g]    = (mode_w == MODE_ONCE);

    gpt_channel #(.DW(DW), .CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .tick_fast (tick_fast),
      .tick_slow (tick_slow),
      .wr_ctrl   (wr_ctrl_v[g]),
      .wr_cksel  (bus_wr && here && (sel == SEL_CKSEL)),
      .wr_cmp    (bus_wr && here && (sel == SEL_CMP)),
      .wdata     (bus_wdata),
      .en_o      (en_v[g]),
      .mode_o    (mode_w),
      .use_slow_o(slow_w),
      .div2_o    (div2_w),
      .count_o   (cnt_w),
      .cmp_o     (cmp_w),
      .match_o   (match_v[g])
    );

    always_comb begin
      word = '0;
      unique case (sel)
        SEL_CTRL: begin
          word[CTRL_EN_BIT]          = en_v[g];
          word[CTRL_MODE_LO +: 2]    = mode_w;
        end
        SEL_CKSEL: begin
          word[CK_SRC_BIT] = slow_w;
          word[CK_DIV_BIT] = div2_w;
        end
        SEL_COUNT: word[CNT_W-1:0] = cnt_w;
        default:   word[CNT_W-1:0] = cmp_w;
      endcase
    end

    assign chan_word[g] = word;
  end

  gpt_irq_ctrl #(.NCH(NCH)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .wr_ie (wr_ie),
    .wr_ack(wr_ack),
    .wbits (bus_wdata[NCH-1:0]),
    .match (match_v),
    .ie_o  (ie_v),
    .pend_o(pend_v),
    .irq_o (irq)
  );

  always_comb begin
    rd_mux = '0;
    if (aligned && (win == '0)) begin
      if (sel == 2'd0)      rd_mux[NCH-1:0] = ie_v;
      else if (sel == 2'd2) rd_mux[NCH-1:0] = pend_v;
    end
    for (int k = 0; k < NCH; k++) begin
      if (aligned && (win == IDX_W'(k + 1))) rd_mux = chan_word[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/gpt_checker.sv
module gpt_checker #(
  parameter int NCH = 6,
  parameter int DW  = 32,
  parameter int AW  = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] match_v,
  input logic [NCH-1:0] pend_v,
  input logic [NCH-1:0] ie_v,
  input logic [NCH-1:0] en_v,
  input logic [NCH-1:0] once_v,
  input logic [NCH-1:0] wr_ctrl_v,
  input logic           wr_ack,
  input logic [DW-1:0]  wdata,
  input logic           irq,
  input logic           bus_rd,
  input logic [AW-1:0]  bus_addr,
  input logic [DW-1:0]  bus_rdata
);

  for (genvar i = 0; i < NCH; i++) begin : g_prop
    // R10: a match leaves its flag set, even against an acknowledge
    p_match_sets_r10: assert property (@(posedge clk) disable iff (rst)
      match_v[i] |=> pend_v[i]);

    // R9: acknowledge without a match clears the flag
    p_ack_clears_r9: assert property (@(posedge clk) disable iff (rst)
      (wr_ack && wdata[i] && !match_v[i]) |=> !pend_v[i]);

    // R8: flag changes only through match or acknowledge
    p_pend_holds_r8: assert property (@(posedge clk) disable iff (rst)
      (!match_v[i] && !(wr_ack && wdata[i])) |=> (pend_v[i] == $past(pend_v[i])));

    // R6: one-shot match drops the enable
    p_once_stops_r6: assert property (@(posedge clk) disable iff (rst)
      (match_v[i] && once_v[i] && !wr_ctrl_v[i]) |=> !en_v[i]);
  end

  // R8: interrupt line follows pending AND enable
  p_irq_level_r8: assert property (@(posedge clk) disable iff (rst)
    irq == |(pend_v & ie_v));

  // R2: clear command never reads back as set
  p_clear_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr[3:0] == 4'h0) && (bus_addr[AW-1:4] != '0)) |=> !bus_rdata[1]);

endmodule

bind gp_timer_bank gpt_checker #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .match_v  (match_v),
  .pend_v   (pend_v),
  .ie_v     (ie_v),
  .en_v     (en_v),
  .once_v   (once_v),
  .wr_ctrl_v(wr_ctrl_v),
  .wr_ack   (wr_ack),
  .wdata    (bus_wdata),
  .irq      (irq),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata)
);

// File: tb/sim_gp_timer_bank.sv
module sim_gp_timer_bank;

  localparam int NCH   = 6;
  localparam int CNT_W = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_fast = 1'b0;
  logic        tick_slow = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  gp_timer_bank #(.NCH(NCH), .DW(32), .AW(8), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_fast(tick_fast),
    .tick_slow(tick_slow), .irq(irq)
  );

  function automatic logic [7:0] a_ctrl(int n);  return 8'(16 * n);     endfunction
  function automatic logic [7:0] a_ck(int n);    return 8'(16 * n + 4); endfunction
  function automatic logic [7:0] a_cnt(int n);   return 8'(16 * n + 8); endfunction
  function automatic logic [7:0] a_cmp(int n);   return 8'(16 * n + 12); endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(int n, bit slow);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (slow) tick_slow = 1'b1; else tick_fast = 1'b1;
      @(negedge clk);
      tick_slow = 1'b0; tick_fast = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: got=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd(8'h00, d); chk("R1 ie reset", d, 32'h0);
    rd(8'h08, d); chk("R1 pending reset", d, 32'h0);
    for (int n = 1; n <= NCH; n++) begin
      rd(a_ctrl(n), d); chk("R1 ctrl reset", d, 32'h0);
      rd(a_cnt(n), d);  chk("R1 count reset", d, 32'h0);
    end

    // R1: per-channel placement of compare and clock select
    for (int n = 1; n <= NCH; n++) begin
      wr(a_cmp(n), 32'(8'h40 + n));
      wr(a_ck(n), (n % 2 == 0) ? 32'h10 : 32'h01);
    end
    for (int n = 1; n <= NCH; n++) begin
      rd(a_cmp(n), d); chk("R1 compare readback", d, 32'(8'h40 + n));
      rd(a_ck(n), d);  chk("R4 clock select readback", d, (n % 2 == 0) ? 32'h10 : 32'h01);
      wr(a_ck(n), 32'h0);
    end

    // R2: clear reads 0, mode and enable read back
    wr(a_ctrl(1), 32'h33);
    rd(a_ctrl(1), d); chk("R2 ctrl readback clear=0", d, 32'h31);

    // R3: counter counts ticks and ignores writes
    pulse(5, 0);
    wr(a_cnt(1), 32'h77);
    rd(a_cnt(1), d); chk("R3 counter write ignored", d, 32'd5);
    wr(a_ctrl(1), 32'h32);
    pulse(4, 0);
    rd(a_cnt(1), d); chk("R3 disabled channel holds", d, 32'd0);

    // R5/R6: sweep compare value and tick count in both interrupting modes
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 5; c++) begin
        for (int k = 0; k < 10; k++) begin
          int ch;
          int ecnt;
          ch = 1 + ((c + k) % NCH);
          wr(a_cmp(ch), 32'(c));
          wr(a_ctrl(ch), 32'h3 | 32'(m << 4));
          wr(8'h08, 32'h3F);
          pulse(k, 0);
          ecnt = (m == 1) ? (k % (c + 1)) : ((k <= c) ? k : c);
          rd(a_cnt(ch), d);
          chk(m == 1 ? "R5 repeat count" : "R6 one-shot count", d, 32'(ecnt));
          rd(8'h08, d);
          chk(m == 1 ? "R5 repeat pending" : "R6 one-shot pending",
              32'(d[ch-1]), 32'(k > c));
          if (m == 0) begin
            rd(a_ctrl(ch), d);
            chk("R6 one-shot enable", 32'(d[0]), 32'(k <= c));
          end
          wr(a_ctrl(ch), 32'h0);
        end
      end
    end

    // R7: free-run wraps and never raises pending
    wr(8'h08, 32'h3F);
    wr(a_cmp(2), 32'd3);
    wr(a_ctrl(2), 32'h33);
    pulse(300, 0);
    rd(a_cnt(2), d); chk("R7 free-run wrap", d, 32'(300 % 256));
    rd(8'h08, d);    chk("R7 free-run no pending", 32'(d[1]), 32'h0);
    wr(a_ctrl(2), 32'h23);
    pulse(10, 0);
    rd(8'h08, d);    chk("R7 mode 2 no pending", 32'(d[1]), 32'h0);
    wr(a_ctrl(2), 32'h0);

    // R4: source select and divide-by-2
    wr(a_ck(3), 32'h10);
    wr(a_ctrl(3), 32'h33);
    pulse(5, 0);
    rd(a_cnt(3), d); chk("R4 slow source ignores fast", d, 32'd0);
    pulse(3, 1);
    rd(a_cnt(3), d); chk("R4 slow source counts", d, 32'd3);
    wr(a_ck(3), 32'h01);
    for (int k = 0; k < 7; k++) begin
      wr(a_ctrl(3), 32'h33);
      pulse(k, 0);
      rd(a_cnt(3), d); chk("R4 divide-by-2", d, 32'(k / 2));
    end
    wr(a_ctrl(3), 32'h0);
    wr(a_ck(3), 32'h0);

    // R8: pending independent of enable; irq follows enable
    wr(8'h08, 32'h3F);
    wr(a_cmp(3), 32'd2);
    wr(a_ctrl(3), 32'h13);
    wr(8'h00, 32'h0);
    pulse(3, 0);
    rd(8'h08, d); chk("R8 pending without enable", 32'(d[2]), 32'h1);
    chk("R8 irq low while disabled", {31'b0, irq}, 32'h0);
    wr(8'h00, 32'h04);
    chk("R8 irq high when enabled", {31'b0, irq}, 32'h1);
    wr(8'h00, 32'h01);
    chk("R8 irq low for other bit", {31'b0, irq}, 32'h0);
    wr(8'h00, 32'h04);
    wr(a_ctrl(3), 32'h0);

    // R9: single-bit acknowledge, then all at once
    wr(a_cmp(5), 32'd0);
    wr(a_ctrl(5), 32'h13);
    pulse(1, 0);
    wr(a_ctrl(5), 32'h0);
    rd(8'h08, d); chk("R9 two pending", d & 32'h3F, 32'h14);
    wr(8'h08, 32'h04);
    rd(8'h08, d); chk("R9 single acknowledge", d & 32'h3F, 32'h10);
    chk("R9 irq drops after ack", {31'b0, irq}, 32'h0);
    wr(8'h08, 32'h3F);
    rd(8'h08, d); chk("R9 acknowledge all", d & 32'h3F, 32'h0);

    // R10: match beats acknowledge in the same cycle
    wr(a_cmp(4), 32'd0);
    wr(a_ctrl(4), 32'h13);
    @(negedge clk);
    tick_fast = 1'b1;
    wr(8'h08, 32'h3F);
    tick_fast = 1'b0;
    rd(8'h08, d); chk("R10 match wins over ack", 32'(d[3]), 32'h1);
    wr(8'h08, 32'h08);
    rd(8'h08, d); chk("R10 later ack clears", 32'(d[3]), 32'h0);

    finish_run();
  end

endmodule